// File: doc/BRIEF.md
# Interrupt Target Routing Register Bank

This block stores, for every interrupt line, an 8-bit set of processors allowed to receive it. Software reaches it through a simple register bus. Each 32-bit word holds four consecutive interrupts. A single access may touch the whole word or any chosen byte lanes.

The first 32 interrupts are private to each processor and have fixed routing. Writes to them are dropped. Reads return a pattern that marks the requesting processor, whose number arrives on a sideband input with the access.

For every shared interrupt (number 32 and above) the bank keeps the stored mask and a registered delivery target. The target is the lowest-numbered processor in the mask, or processor 0 when the mask is empty. These targets go out on a flat per-interrupt output bus for the delivery logic downstream.

Top module: `tgt_route_bank`

## Requirements
- R1: The interrupt number of a byte is the word address times 4 plus the byte lane (lane 0 = bits 7:0, lane 3 = bits 31:24); a write with all four byte enables set updates all four interrupts of that word.
- R2: A write stores only the lanes whose byte enable is set; every other lane keeps its previous value.
- R3: Writes to interrupts 0 to 31 (word addresses 0 to 7) change nothing.
- R4: A read of word addresses 0 to 7 returns, in each enabled lane, a byte with only bit `bus_req_cpu` set.
- R5: Before it is stored, a written byte is ANDed with a mask that has bits 0 to NUM_CPU-1 set.
- R6: The delivery target of a shared interrupt is the index of the lowest set bit of its stored mask, or 0 when the mask is zero.
- R7: The delivery target changes on the clock edge that takes the write, so it is visible one cycle after the write cycle. It holds its value in cycles without a write.
- R8: After reset every shared mask reads as zero and every delivery target is 0.
- R9: Read data and `bus_rvalid` appear in the cycle after `bus_rd`. Lanes whose byte enable is clear read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Word address (interrupt number / 4) |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_req_cpu | input | 3 | Number of the processor making the access |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| route_dest | output | NSH*IW | Delivery target per shared interrupt; interrupt 32+k at bits [k*IW +: IW] |

## Verification
The bench builds the bank with 48 interrupts and 5 processors. With these values, 16 shared entries span four words, so every byte lane of a shared word can be tested. Because only five processors are present, the top three bits of any written byte must be cleared, and the clipping is visible both in read-back and in the derived target. Private words use the same decode as shared words, so the read-only path and the requester-dependent read pattern can be checked directly against shared-word behaviour.

// File: rtl/tgt_route_pkg.sv
package tgt_route_pkg;
    localparam int LANES    = 4;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = LANES * BYTE_W;
    localparam int PRIV_IRQ = 32;

    typedef logic [BYTE_W-1:0] tmask_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
    } rd_state_t;
endpackage

// File: rtl/tgt_low_enc.sv
module tgt_low_enc #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/tgt_route_entry.sv
module tgt_route_entry
    import tgt_route_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  tmask_t        wbyte,
    input  tmask_t        present,
    output tmask_t        mask_o,
    output logic [IW-1:0] dest_o
);
    typedef struct packed {
        tmask_t        mask;
        logic [IW-1:0] dest;
    } entry_t;

    entry_t        ent_d, ent_q;
    tmask_t        clipped;
    logic [IW-1:0] enc_idx;

    assign clipped = wbyte & present;

    tgt_low_enc #(.W(BYTE_W), .IW(IW)) u_enc (
        .vec (clipped),
        .idx (enc_idx)
    );

    always_comb begin
        ent_d = ent_q;
        if (wr_hit) begin
            ent_d.mask = clipped;
            ent_d.dest = enc_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign mask_o = ent_q.mask;
    assign dest_o = ent_q.dest;
endmodule

// File: rtl/tgt_route_bank.sv
module tgt_route_bank
    import tgt_route_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 8,
    localparam int NWORDS = NUM_IRQ / LANES,
    localparam int AW     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int NSH    = NUM_IRQ - PRIV_IRQ,
    localparam int IW     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [2:0]        bus_req_cpu,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [NSH*IW-1:0] route_dest
);
    localparam int     PRIV_WORDS = PRIV_IRQ / LANES;
    localparam tmask_t PRESENT    = tmask_t'((9'd1 << NUM_CPU) - 9'd1);

    logic [NSH*BYTE_W-1:0] sh_flat;
    rd_state_t             rd_d, rd_q;

    for (genvar g = 0; g < NSH; g++) begin : g_entry
        localparam int IRQ  = PRIV_IRQ + g;
        localparam int WORD = IRQ / LANES;
        localparam int LANE = IRQ % LANES;
        logic hit;
        assign hit = bus_wr && (bus_addr == AW'(WORD)) && bus_be[LANE];

        tgt_route_entry #(.IW(IW)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (hit),
            .wbyte   (bus_wdata[LANE*BYTE_W +: BYTE_W]),
            .present (PRESENT),
            .mask_o  (sh_flat[g*BYTE_W +: BYTE_W]),
            .dest_o  (route_dest[g*IW +: IW])
        );
    end

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = bus_rd;
        if (bus_rd) begin
            rd_d.rdata = '0;
            for (int l = 0; l < LANES; l++) begin
                if (bus_be[l]) begin
                    if (int'(bus_addr) < PRIV_WORDS) begin
                        rd_d.rdata[l*BYTE_W +: BYTE_W] = tmask_t'(9'd1 << bus_req_cpu);
                    end else if (int'(bus_addr) < NWORDS) begin
                        rd_d.rdata[l*BYTE_W +: BYTE_W] =
                            sh_flat[((int'(bus_addr) - PRIV_WORDS) * LANES + l) * BYTE_W +: BYTE_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata  = rd_q.rdata;
    assign bus_rvalid = rd_q.rvalid;
endmodule

// File: rtl/tgt_route_bank_chk.sv
module tgt_route_bank_chk
    import tgt_route_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 8,
    localparam int NWORDS = NUM_IRQ / LANES,
    localparam int AW     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int NSH    = NUM_IRQ - PRIV_IRQ,
    localparam int IW     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [AW-1:0]     bus_addr,
    input logic [LANES-1:0]  bus_be,
    input logic [2:0]        bus_req_cpu,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic [NSH*IW-1:0] route_dest
);
    localparam int PRIV_WORDS = PRIV_IRQ / LANES;

    // R9: read data valid follows a read strobe by one cycle
    p_rvalid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R9: a lane without enable reads zero
    p_lane0_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_be[0]) |=> (bus_rdata[7:0] == 8'h00));

    // R4: private word returns the requester's bit
    p_private_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (int'(bus_addr) < PRIV_WORDS) && bus_be[0])
        |=> (bus_rdata[7:0] == 8'(9'd1 << $past(bus_req_cpu))));

    // R7: targets hold when nothing is written
    p_dest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(route_dest));

    // R7: private-word writes never move any target (R3)
    p_priv_write_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (int'(bus_addr) < PRIV_WORDS)) |=> $stable(route_dest));

    // R5: every target names a present processor
    for (genvar g = 0; g < NSH; g++) begin : g_rng
        p_dest_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
            int'(route_dest[g*IW +: IW]) < NUM_CPU);
    end
endmodule

bind tgt_route_bank tgt_route_bank_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_req_cpu (bus_req_cpu),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .route_dest  (route_dest)
);

// File: tb/tgt_route_bank_bench.sv
`timescale 1ns/1ps
module tgt_route_bank_bench;
    localparam int NUM_IRQ = 48;
    localparam int NUM_CPU = 5;
    localparam int AW      = 4;
    localparam int IW      = 3;
    localparam int NSH     = NUM_IRQ - 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic [2:0]        bus_req_cpu = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NSH*IW-1:0] route_dest;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tgt_route_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_tgt_route_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_req_cpu(bus_req_cpu), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .route_dest(route_dest)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] rexp;
        logic [5:0]  irq;
        logic [2:0]  dexp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'd8,  4'hF, 32'h04100106, 32'h04100106, 6'd32, 3'd1},
        '{4'd9,  4'hF, 32'hFFE08018, 32'h1F000018, 6'd36, 3'd3},
        '{4'd9,  4'h0, 32'h00000000, 32'h1F000018, 6'd37, 3'd0},
        '{4'd10, 4'h4, 32'h00300000, 32'h00100000, 6'd42, 3'd4},
        '{4'd11, 4'h8, 32'h0A000000, 32'h0A000000, 6'd47, 3'd1},
        '{4'd10, 4'h1, 32'h000000E8, 32'h00100008, 6'd40, 3'd3},
        '{4'd8,  4'h4, 32'h00200000, 32'h04000106, 6'd34, 3'd0}
    };

    function automatic logic [2:0] dest_of(input int irq);
        return route_dest[(irq-32)*IW +: IW];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic do_read(input logic [3:0] a, input logic [3:0] be, input logic [2:0] cpu,
                           output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_be = be; bus_req_cpu = cpu;
        @(negedge clk);
        bus_rd = 1'b0; bus_be = '0;
        check("R9 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        do_read(4'd8, 4'hF, 3'd0, rd);
        check("R8 mask reset", rd, 32'h0);
        for (int k = 32; k < NUM_IRQ; k++) check("R8 dest reset", 32'(dest_of(k)), 32'd0);

        // R1 R2 R5 R6: table walk
        for (int v = 0; v < 7; v++) begin
            if (VECS[v].be != 4'h0) do_write(VECS[v].addr, VECS[v].be, VECS[v].wdata);
            do_read(VECS[v].addr, 4'hF, 3'd0, rd);
            check("R1 R2 R5 readback", rd, VECS[v].rexp);
            check("R6 dest", 32'(dest_of(int'(VECS[v].irq))), 32'(VECS[v].dexp));
        end

        // R3 R4: private words read-only, requester pattern
        do_write(4'd0, 4'hF, 32'hFFFFFFFF);
        do_read(4'd0, 4'hF, 3'd3, rd);
        check("R3 R4 private read cpu3", rd, 32'h08080808);
        do_read(4'd7, 4'hF, 3'd0, rd);
        check("R4 private read cpu0", rd, 32'h01010101);
        check("R3 dest untouched", 32'(dest_of(32)), 32'd1);

        // R9: lanes without enable read zero
        do_read(4'd9, 4'h1, 3'd0, rd);
        check("R9 byte read lane0", rd, 32'h00000018);
        do_read(4'd11, 4'h8, 3'd0, rd);
        check("R9 byte read lane3", rd, 32'h0A000000);
        do_read(4'd9, 4'h2, 3'd0, rd);
        check("R9 byte read lane1", rd, 32'h0);

        // R7: target changes only after the write edge
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd9; bus_be = 4'h1; bus_wdata = 32'h00000004;
        check("R7 dest before edge", 32'(dest_of(36)), 32'd3);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        check("R7 dest after edge", 32'(dest_of(36)), 32'd2);
        @(negedge clk);
        check("R7 dest holds", 32'(dest_of(36)), 32'd2);

        // R5: full clip to empty gives target 0
        do_write(4'd11, 4'h8, 32'hE0000000);
        check("R5 R6 clipped empty", 32'(dest_of(47)), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule